// File: doc/BRIEF.md
# Boot Code Loader with Selectable Source

This block fills the program memory of an embedded processor after reset and keeps that processor in reset until the image is complete. A strap input picks one of two sources. With the strap low, the block drives its own two-wire bus as master and reads the image from a serial EEPROM. With the strap high, the external host writes the image one byte at a time into the device's code-input port. Each of these writes carries the 7-bit slave address of the transfer, and the block accepts only those that match its own address.

Both sources deliver the same image format. The first two bytes give the code length, most significant byte first. The data bytes follow and are written to consecutive program memory addresses starting at zero. When the last byte has been stored the block raises a done flag, and the same flag releases the processor's reset. If the EEPROM fails to acknowledge any byte the master writes, the block ends the transfer with a STOP, raises an error flag and keeps the processor in reset.

Top module: `boot_loader`

## Requirements
- R1: The strap `boot_src_i` is captured on the first clock edge after reset is released (0 = EEPROM, 1 = host). Later changes to the strap have no effect until the next reset.
- R2: An EEPROM boot issues these steps in order: START; the address byte {1,0,1,0,0,0,`eep_sel_i`,0}; word address bytes 0x00 and 0x00; a repeated START; the same address with the read bit 1; a sequential read that ACKs every byte except the last, which gets a NACK; and a single STOP.
- R3: Image byte 0 is the high byte and byte 1 the low byte of a 16-bit length N. Image bytes 2 to N+1 are written to program memory addresses 0 to N-1, in that order.
- R4: If the EEPROM does not acknowledge any byte the master writes, the boot stops. A STOP is sent, `err_o` goes high, no program memory write takes place, and `done_o` and `cpu_rst_no` stay low.
- R5: `done_o` rises in the clock cycle after the last program memory write, or after the length bytes when N = 0. `cpu_rst_no` follows `done_o`.
- R6: In host mode a byte is taken only when `host_wr_i` is high and `host_addr_i` equals {0,0,0,1,0,`dev_sel_i`}. All other writes are ignored, and the EEPROM bus stays idle (SCL high, SDA released).
- R7: Once `done_o` is high, further bytes from either source cause no program memory write.
- R8: Every bit on the EEPROM bus lasts 4*DIV clock cycles, and SCL is high in the middle two quarters. SDA is only ever pulled low (open drain) and changes only while SCL is low, except for START and STOP.
- R9: The reset `rst_ni` is asynchronous and active low. While it is low the bus is idle and `done_o`, `err_o` and `cpu_rst_no` are low, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_src_i | input | 1 | Boot source strap, 0 = EEPROM, 1 = host |
| eep_sel_i | input | 1 | LSB of the EEPROM bus address |
| dev_sel_i | input | 2 | Two LSBs of this device's slave address |
| host_wr_i | input | 1 | Host wrote the code-input port this cycle |
| host_addr_i | input | 7 | Slave address of that host write |
| host_data_i | input | 8 | Byte written by the host |
| scl_o | output | 1 | EEPROM bus clock |
| sda_oe_o | output | 1 | 1 pulls EEPROM SDA low, 0 releases it |
| sda_i | input | 1 | EEPROM SDA line level |
| pm_we_o | output | 1 | Program memory write strobe |
| pm_addr_o | output | AW | Program memory write address |
| pm_data_o | output | 8 | Program memory write data |
| done_o | output | 1 | Image fully loaded |
| err_o | output | 1 | EEPROM did not acknowledge |
| cpu_rst_no | output | 1 | Active-low processor reset, released at done |

## Verification
The assertions assume that the EEPROM changes SDA only while SCL is low and never stretches the clock. They also assume that the image length does not exceed the program memory depth, 2^AW. The bench EEPROM model changes its SDA drive only after it has seen SCL fall, and the random image lengths stay at 30 bytes or fewer. Host writes are driven at the falling clock edge with random data, and writes to a wrong address are interleaved with the valid ones. Error cases come from a model whose address LSB differs from the strap.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_WRITE, CMD_READ} i2c_cmd_e;
  typedef enum logic [3:0] {S_IDLE, S_STA1, S_DEVW, S_WAH, S_WAL, S_STA2, S_DEVR,
                            S_READ, S_STOP, S_END} eep_st_e;
  typedef enum logic [1:0] {K_LEN_HI, K_LEN_LO, K_BODY, K_FIN} sink_st_e;
  localparam logic [5:0] EEP_ADDR_HI = 6'b101000;
  localparam logic [4:0] DEV_ADDR_HI = 5'b00010;
endpackage

// File: rtl/boot_i2c_phy.sv
module boot_i2c_phy import boot_pkg::*; #(
  parameter int DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  i2c_cmd_e   cmd_i,
  input  logic [7:0] tx_i,
  input  logic       ack_i,
  input  logic       sda_i,
  output logic       done_o,
  output logic       nack_o,
  output logic [7:0] rx_o,
  output logic       scl_o,
  output logic       sda_oe_o
);
  localparam int DW = $clog2(DIV + 1);

  logic [DW-1:0] div_q;
  logic [1:0]    ph_q;
  logic [3:0]    bit_q;
  i2c_cmd_e      cmd_q;
  logic          busy_q, scl_hold_q, nack_q;
  logic [7:0]    sh_q;
  logic          tick, is_data;

  assign tick    = div_q == DW'(DIV - 1);
  assign is_data = (cmd_q == CMD_WRITE) || (cmd_q == CMD_READ);
  assign nack_o  = nack_q;
  assign rx_o    = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0; ph_q <= '0; bit_q <= '0; cmd_q <= CMD_STOP;
      busy_q <= 1'b0; scl_hold_q <= 1'b1; nack_q <= 1'b0; sh_q <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (cmd_valid_i) begin
          busy_q <= 1'b1; cmd_q <= cmd_i; sh_q <= tx_i;
          div_q <= '0; ph_q <= '0; bit_q <= '0;
        end
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          ph_q <= ph_q + 1'b1;
          if (ph_q == 2'd1 && is_data) begin
            if (bit_q == 4'd8) nack_q <= sda_i;
            else if (cmd_q == CMD_READ) sh_q <= {sh_q[6:0], sda_i};
          end
          if (ph_q == 2'd3) begin
            if (!is_data || bit_q == 4'd8) begin
              busy_q <= 1'b0; done_o <= 1'b1;
              scl_hold_q <= (cmd_q == CMD_STOP);
            end else begin
              bit_q <= bit_q + 1'b1;
              if (cmd_q == CMD_WRITE) sh_q <= {sh_q[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  // quarters: 0 low, 1-2 high, 3 low; START/STOP move SDA while SCL is high
  always_comb begin
    scl_o = scl_hold_q;
    sda_oe_o = 1'b0;
    if (busy_q) begin
      unique case (cmd_q)
        CMD_START: begin scl_o = ph_q inside {2'd1, 2'd2}; sda_oe_o = ph_q[1]; end
        CMD_STOP:  begin scl_o = ph_q != 2'd0; sda_oe_o = !ph_q[1]; end
        default: begin
          scl_o = ph_q inside {2'd1, 2'd2};
          if (bit_q == 4'd8) sda_oe_o = (cmd_q == CMD_READ) && ack_i;
          else               sda_oe_o = (cmd_q == CMD_WRITE) && !sh_q[7];
        end
      endcase
    end
  end

  a_r8_sda_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && is_data && scl_o && $past(scl_o) |-> $stable(sda_oe_o));
endmodule

// File: rtl/boot_eep_seq.sv
module boot_eep_seq import boot_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       sel_i,
  input  logic       phy_done_i,
  input  logic       phy_nack_i,
  input  logic [7:0] phy_rx_i,
  input  logic       last_i,
  output logic       cmd_valid_o,
  output i2c_cmd_e   cmd_o,
  output logic [7:0] tx_o,
  output logic       ack_o,
  output logic       byte_valid_o,
  output logic [7:0] byte_o,
  output logic       err_o
);
  eep_st_e st_q;
  logic    wait_q, err_q;

  assign cmd_valid_o  = !wait_q && st_q != S_IDLE && st_q != S_END;
  assign ack_o        = !last_i;
  assign byte_valid_o = phy_done_i && st_q == S_READ;
  assign byte_o       = phy_rx_i;
  assign err_o        = err_q;

  always_comb begin
    unique case (st_q)
      S_STA1, S_STA2:               cmd_o = CMD_START;
      S_DEVW, S_WAH, S_WAL, S_DEVR: cmd_o = CMD_WRITE;
      S_READ:                       cmd_o = CMD_READ;
      default:                      cmd_o = CMD_STOP;
    endcase
    unique case (st_q)
      S_DEVW:  tx_o = {EEP_ADDR_HI, sel_i, 1'b0};
      S_DEVR:  tx_o = {EEP_ADDR_HI, sel_i, 1'b1};
      default: tx_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; wait_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (cmd_valid_o) wait_q <= 1'b1;
      if (st_q == S_IDLE && start_i) st_q <= S_STA1;
      if (phy_done_i) begin
        wait_q <= 1'b0;
        unique case (st_q)
          S_STA1: st_q <= S_DEVW;
          S_STA2: st_q <= S_DEVR;
          S_DEVW, S_WAH, S_WAL, S_DEVR: begin
            if (phy_nack_i) begin
              err_q <= 1'b1; st_q <= S_STOP;
            end else begin
              unique case (st_q)
                S_DEVW:  st_q <= S_WAH;
                S_WAH:   st_q <= S_WAL;
                S_WAL:   st_q <= S_STA2;
                default: st_q <= S_READ;
              endcase
            end
          end
          S_READ:  if (last_i) st_q <= S_STOP;
          S_STOP:  st_q <= S_END;
          default: ;
        endcase
      end
    end
  end

  a_r4_no_read_after_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !byte_valid_o);
endmodule

// File: rtl/boot_image_sink.sv
module boot_image_sink import boot_pkg::*; #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_i,
  input  logic [7:0]    peek_i,
  output logic          peek_last_o,
  output logic          pm_we_o,
  output logic [AW-1:0] pm_addr_o,
  output logic [7:0]    pm_data_o,
  output logic          done_o
);
  sink_st_e    st_q;
  logic [15:0] len_q, cnt_q;
  logic        body_last;

  assign body_last = cnt_q == len_q - 16'd1;

  always_comb begin
    unique case (st_q)
      K_LEN_LO: peek_last_o = {len_q[15:8], peek_i} == 16'd0;
      K_BODY:   peek_last_o = body_last;
      default:  peek_last_o = 1'b0;
    endcase
  end

  assign pm_we_o   = byte_valid_i && st_q == K_BODY;
  assign pm_addr_o = cnt_q[AW-1:0];
  assign pm_data_o = byte_i;
  assign done_o    = st_q == K_FIN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= K_LEN_HI; len_q <= '0; cnt_q <= '0;
    end else if (byte_valid_i) begin
      unique case (st_q)
        K_LEN_HI: begin len_q[15:8] <= byte_i; st_q <= K_LEN_LO; end
        K_LEN_LO: begin
          len_q[7:0] <= byte_i; cnt_q <= '0;
          st_q <= ({len_q[15:8], byte_i} == 16'd0) ? K_FIN : K_BODY;
        end
        K_BODY: begin
          cnt_q <= cnt_q + 16'd1;
          if (body_last) st_q <= K_FIN;
        end
        default: ;
      endcase
    end
  end

  a_r7_no_write_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !pm_we_o);
  a_r5_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_we_o |=> pm_addr_o == $past(pm_addr_o) + 1'b1);
endmodule

// File: rtl/boot_loader.sv
module boot_loader import boot_pkg::*; #(
  parameter int AW  = 10,
  parameter int DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          boot_src_i,
  input  logic          eep_sel_i,
  input  logic [1:0]    dev_sel_i,
  input  logic          host_wr_i,
  input  logic [6:0]    host_addr_i,
  input  logic [7:0]    host_data_i,
  output logic          scl_o,
  output logic          sda_oe_o,
  input  logic          sda_i,
  output logic          pm_we_o,
  output logic [AW-1:0] pm_addr_o,
  output logic [7:0]    pm_data_o,
  output logic          done_o,
  output logic          err_o,
  output logic          cpu_rst_no
);
  logic       started_q, src_q;
  logic       cmd_valid, phy_done, phy_nack, ack, last;
  i2c_cmd_e   cmd;
  logic [7:0] tx, rx, eep_byte, sink_byte;
  logic       eep_valid, host_valid, sink_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0; src_q <= 1'b0;
    end else if (!started_q) begin
      started_q <= 1'b1; src_q <= boot_src_i;
    end
  end

  assign host_valid = started_q && src_q && host_wr_i &&
                      host_addr_i == {DEV_ADDR_HI, dev_sel_i};
  assign sink_valid = src_q ? host_valid : eep_valid;
  assign sink_byte  = src_q ? host_data_i : eep_byte;
  assign cpu_rst_no = done_o;

  boot_i2c_phy #(.DIV(DIV)) i_phy (
    .clk_i, .rst_ni, .cmd_valid_i(cmd_valid), .cmd_i(cmd), .tx_i(tx), .ack_i(ack),
    .sda_i, .done_o(phy_done), .nack_o(phy_nack), .rx_o(rx), .scl_o, .sda_oe_o);

  boot_eep_seq i_seq (
    .clk_i, .rst_ni, .start_i(started_q && !src_q), .sel_i(eep_sel_i),
    .phy_done_i(phy_done), .phy_nack_i(phy_nack), .phy_rx_i(rx), .last_i(last),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .tx_o(tx), .ack_o(ack),
    .byte_valid_o(eep_valid), .byte_o(eep_byte), .err_o);

  boot_image_sink #(.AW(AW)) i_sink (
    .clk_i, .rst_ni, .byte_valid_i(sink_valid), .byte_i(sink_byte), .peek_i(rx),
    .peek_last_o(last), .pm_we_o, .pm_addr_o, .pm_data_o, .done_o);

  a_r1_src_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> started_q && $stable(src_q));
  a_r6_host_bus_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && src_q |-> scl_o && !sda_oe_o);
  a_r4_err_blocks_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o && !pm_we_o);
endmodule

// File: tb/test_boot_loader.sv
module test_boot_loader;
  localparam int AW = 10;
  localparam int DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic boot_src = 1'b0, eep_sel = 1'b0, host_wr = 1'b0;
  logic [1:0] dev_sel = 2'b00;
  logic [6:0] host_addr = '0;
  logic [7:0] host_data = '0;
  logic scl, sda_oe, pm_we, done, err, cpu_rst_n;
  logic [AW-1:0] pm_addr;
  logic [7:0] pm_data;
  logic m_low = 1'b0;
  logic sda_line;

  always #5 clk = !clk;
  assign sda_line = !(sda_oe || m_low);

  boot_loader #(.AW(AW), .DIV(DIV)) i_boot_loader (
    .clk_i(clk), .rst_ni(rst_n), .boot_src_i(boot_src), .eep_sel_i(eep_sel),
    .dev_sel_i(dev_sel), .host_wr_i(host_wr), .host_addr_i(host_addr),
    .host_data_i(host_data), .scl_o(scl), .sda_oe_o(sda_oe), .sda_i(sda_line),
    .pm_we_o(pm_we), .pm_addr_o(pm_addr), .pm_data_o(pm_data), .done_o(done),
    .err_o(err), .cpu_rst_no(cpu_rst_n));

  int n_chk = 0, n_err = 0, cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] img(int p, int len, int seed);
    if (p == 0) return len[15:8];
    if (p == 1) return len[7:0];
    return 8'((p * 37 + seed) ^ (p >> 3));
  endfunction

  // program memory capture
  logic [7:0] pm_mem [0:1023];
  int pm_writes, pm_order_bad, last_we_cyc, done_cyc;
  logic done_prev;
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      pm_writes = 0; pm_order_bad = 0; last_we_cyc = -1; done_cyc = -1; done_prev = 0;
    end else begin
      if (pm_we) begin
        if (int'(pm_addr) != pm_writes) pm_order_bad++;
        pm_mem[pm_addr] = pm_data; pm_writes++; last_we_cyc = cyc;
      end
      if (done && !done_prev) done_cyc = cyc;
      done_prev = done;
    end
  end

  // EEPROM model: modes 1 addr, 2 word hi, 3 word lo, 4 wait restart, 5 read, 6 ignore
  logic m_sel = 1'b0;
  int m_len = 0, m_seed = 0;
  int m_mode, m_bit, m_ptr, m_starts, m_stops, m_nreads, m_final_nack, m_per_bad, m_per_cnt;
  int m_last_rise, m_falls;
  logic [15:0] m_wa;
  logic [7:0] m_sh, m_cur;
  logic m_rd, m_mack, m_skip, p_scl, p_sda;
  always @(negedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_bit = 0; m_ptr = 0; m_starts = 0; m_stops = 0; m_nreads = 0;
      m_final_nack = 0; m_per_bad = 0; m_per_cnt = 0; m_last_rise = 0; m_falls = 0;
      m_wa = 16'hffff; m_sh = 0; m_cur = 0; m_rd = 0; m_mack = 0; m_skip = 0;
      m_low = 0; p_scl = 1; p_sda = 1;
    end else begin
      if (!scl && p_scl) m_falls++;
      if (scl && p_scl && p_sda && !sda_line) begin
        m_starts++; m_mode = 1; m_bit = 0; m_low = 0; m_skip = 1;
      end else if (scl && p_scl && !p_sda && sda_line) begin
        m_stops++; m_mode = 0; m_low = 0;
      end else if (scl && !p_scl) begin
        if (m_mode == 5 && m_bit >= 1 && m_bit <= 8) begin
          m_per_cnt++;
          if (cyc - m_last_rise != 4 * DIV) m_per_bad++;
        end
        m_last_rise = cyc;
        if (m_bit < 8) m_sh = {m_sh[6:0], sda_line}; else m_mack = !sda_line;
      end else if (!scl && p_scl && m_mode != 0 && m_mode != 6) begin
        if (m_skip) m_skip = 0;
        else if (m_bit < 8) begin
          m_bit++;
          if (m_mode == 5) m_low = (m_bit < 8) ? !m_cur[7 - m_bit] : 1'b0;
          else if (m_bit == 8) begin
            case (m_mode)
              1: if (m_sh[7:1] == {6'b101000, m_sel}) begin m_low = 1; m_rd = m_sh[0]; end
                 else begin m_low = 0; m_mode = 6; end
              2: begin m_wa[15:8] = m_sh; m_low = 1; end
              3: begin m_wa[7:0] = m_sh; m_ptr = int'(m_wa); m_low = 1; end
              default: m_low = 0;
            endcase
          end
        end else begin
          m_bit = 0;
          case (m_mode)
            1: if (m_rd) begin
                 m_mode = 5; m_cur = img(m_ptr, m_len, m_seed); m_low = !m_cur[7];
               end else begin m_mode = 2; m_low = 0; end
            2: begin m_mode = 3; m_low = 0; end
            3: begin m_mode = 4; m_low = 0; end
            5: begin
                 m_nreads++;
                 if (m_mack) begin
                   m_ptr++; m_cur = img(m_ptr, m_len, m_seed); m_low = !m_cur[7];
                 end else begin m_low = 0; m_mode = 6; m_final_nack = 1; end
               end
            default: m_low = 0;
          endcase
        end
      end
      p_scl = scl; p_sda = sda_line;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic eep_boot(input int len, input int seed, input logic sel, input logic msel,
                          input logic flip);
    int bad;
    m_len = len; m_seed = seed; m_sel = msel; eep_sel = sel; boot_src = 1'b0;
    do_reset();
    repeat (2) @(negedge clk);
    if (flip) boot_src = 1'b1;  // R1: late strap change must not matter
    for (int i = 0; i < 20000 && !(done || err); i++) @(negedge clk);
    repeat (24) @(negedge clk);
    if (sel == msel) begin
      chk("R5 done", int'(done), 1);
      chk("R5 cpu reset released", int'(cpu_rst_n), 1);
      chk("R4 no err", int'(err), 0);
      chk("R3 write count", pm_writes, len);
      chk("R3 address order", pm_order_bad, 0);
      bad = 0;
      for (int i = 0; i < len; i++) if (pm_mem[i] !== img(i + 2, len, seed)) bad++;
      chk("R3 data", bad, 0);
      chk("R2 starts", m_starts, 2);
      chk("R2 stops", m_stops, 1);
      chk("R2 word address", int'(m_wa), 0);
      chk("R2 reads", m_nreads, len + 2);
      chk("R2 final nack", m_final_nack, 1);
      chk("R8 bit period", m_per_bad, 0);
      chk("R8 periods seen", int'(m_per_cnt > 0), 1);
      if (len > 0) chk("R5 done timing", done_cyc, last_we_cyc + 1);
    end else begin
      chk("R4 err", int'(err), 1);
      chk("R4 not done", int'(done), 0);
      chk("R4 cpu held", int'(cpu_rst_n), 0);
      chk("R4 no writes", pm_writes, 0);
      chk("R4 stop sent", m_stops, 1);
    end
  endtask

  task automatic host_wr_byte(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_data = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] hd [0:63];
    logic [6:0] me;
    int hl, bad, w0, scl_low_before;
    void'($urandom(32'h1dc0de));

    // reset state, host mode selected
    boot_src = 1'b1; dev_sel = 2'b10;
    do_reset();
    @(negedge clk);
    chk("R9 reset scl", int'(scl), 1);
    chk("R9 reset sda", int'(sda_oe), 0);
    chk("R5 reset done", int'(done), 0);
    chk("R4 reset err", int'(err), 0);
    chk("R5 reset cpu held", int'(cpu_rst_n), 0);
    boot_src = 1'b0;  // R1: ignored after capture

    // host boot with interleaved foreign writes
    me = {5'b00010, dev_sel};
    hl = 25;
    scl_low_before = m_falls;
    host_wr_byte(me, 8'(hl >> 8));
    host_wr_byte(me ^ 7'h01, 8'h55);
    host_wr_byte(me, 8'(hl));
    for (int i = 0; i < hl; i++) begin
      hd[i] = 8'($urandom);
      if ($urandom % 3 == 0) host_wr_byte(me ^ 7'h20, 8'($urandom));
      if (i == hl - 1) chk("R5 not done before last", int'(done), 0);
      host_wr_byte(me, hd[i]);
    end
    @(negedge clk);
    chk("R6 host done", int'(done), 1);
    chk("R6 host cpu released", int'(cpu_rst_n), 1);
    chk("R6 host write count", pm_writes, hl);
    bad = 0;
    for (int i = 0; i < hl; i++) if (pm_mem[i] !== hd[i]) bad++;
    chk("R6 host data", bad, 0);
    chk("R5 host done timing", done_cyc, last_we_cyc + 1);
    chk("R1 R6 bus idle in host mode", m_falls - scl_low_before, 0);
    chk("R6 scl high", int'(scl), 1);
    w0 = pm_writes;
    host_wr_byte(me, 8'hA5);
    host_wr_byte(me, 8'h5A);
    chk("R7 no write after done", pm_writes, w0);

    // EEPROM boots: directed then random
    eep_boot(20, 7, 1'b1, 1'b1, 1'b1);
    eep_boot(0, 3, 1'b0, 1'b0, 1'b0);
    eep_boot(1, 9, 1'b0, 1'b0, 1'b0);
    eep_boot(10, 5, 1'b1, 1'b0, 1'b0);
    eep_boot(10, 5, 1'b0, 1'b1, 1'b0);
    for (int r = 0; r < 3; r++) begin
      logic s;
      s = 1'($urandom);
      eep_boot(1 + int'($urandom % 30), int'($urandom % 256), s, s, 1'($urandom));
    end
    w0 = pm_writes;
    host_wr_byte({5'b00010, dev_sel}, 8'h11);
    chk("R7 R6 host ignored in eeprom mode", pm_writes, w0);

    // asynchronous reset in the middle of a transfer
    m_len = 30; m_sel = 1'b0; eep_sel = 1'b0; boot_src = 1'b0;
    do_reset();
    repeat (300) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R9 async scl", int'(scl), 1);
    chk("R9 async sda", int'(sda_oe), 0);
    chk("R9 async done", int'(done), 0);
    chk("R9 async cpu held", int'(cpu_rst_n), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule